// File: doc/BRIEF.md
# Loop-Sampled Edge Counter

This block counts transitions on one selected input pin, but it looks at that pin only once per loop period. A fast clock is first divided by a programmable high-resolution prescaler (divide by N+1) and then by a power-of-two loop prescaler, giving a single loop tick every (N+1)·2^L clock cycles. On each loop tick the synchronized pin level is compared with the level captured on the previous tick. If the pair matches the configured edge type, the count advances by one.

Because each loop tick evaluates one pair of samples, at most one edge is counted per loop period. A periodic input is counted correctly only while its frequency stays at or below half the loop tick rate. Beyond that limit, edges alias away and the count falls short. The prescale fields therefore set the usable input bandwidth directly. Software uses a small four-word register port to configure the block, read and reset the count, and service a sticky interrupt flag.

Top module: `loop_edge_counter`

## Requirements
- R1: The high-resolution divider produces one tick every N+1 clock cycles, where N is configuration word bits 5:0. A value of 0 ticks on every clock.
- R2: The loop tick repeats every (N+1)·2^L clock cycles, with L in configuration word bits 10:8. The value 0x500 gives 32 cycles. Writing the configuration word (address 0) restarts both dividers.
- R3: The selected pin passes through two clock-domain flops and is sampled once per loop tick. A level that is held for at least one loop period is seen by at least one tick.
- R4: Control word (address 1) bits 1:0 select the edge type. The encodings are 00 none, 01 rising, 10 falling and 11 both. A rising edge means the previous sample was 0 and the new sample is 1; a falling edge is the reverse.
- R5: An input whose period equals one loop period is sampled at a fixed phase and adds nothing to the count.
- R6: The count changes by at most one per loop tick. Between ticks it changes only through a count reset.
- R7: The count saturates at all-ones and does not wrap. The overflow flag (status bit 1) sets when the count reaches all-ones and stays set until the next count reset.
- R8: A write to address 2 sets the count to 0 and clears overflow on the next clock. An edge detected in that same cycle is dropped and does not raise the interrupt.
- R9: With control bit 8 set, each counted edge sets the interrupt flag (output `irq`, status bit 0). Writing 1 to bit 0 of address 3 clears it. Writing 0 to that bit leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R10: Control bits 7:4 select the pin index. Transitions on any other pin have no effect.
- R11: Reads return the configuration word at address 0, the control word at 1, the zero-extended count at 2 and the status at 3. After reset, all four read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins | input | NUM_PINS | Asynchronous input pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Sticky edge interrupt flag |

## Verification
The bench builds the block with a 4-bit counter and four pins. Saturation and the overflow flag are reached after fifteen rising edges instead of millions. The 3-bit loop field and 6-bit high-resolution field keep their default widths, so loop periods from 1 to 32 cycles are exercised, including the 0x500 setting. Aliasing is exercised by toggling at exactly the loop rate, and the dropped-edge rule by a reset strobe aligned to a detected edge.

// File: rtl/lec_pkg.sv
package lec_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // Decide whether a pair of loop samples forms a qualifying edge.
  function automatic logic edge_match(edge_mode_e mode, logic prev_lvl, logic new_lvl);
    logic up, down;
    up   = !prev_lvl && new_lvl;
    down = prev_lvl && !new_lvl;
    case (mode)
      EDGE_RISE: return up;
      EDGE_FALL: return down;
      EDGE_BOTH: return up || down;
      default:   return 1'b0;
    endcase
  endfunction

  // Clock cycles between loop ticks.
  function automatic int unsigned loop_period(int unsigned hr_div, int unsigned lp_exp);
    return (hr_div + 1) << lp_exp;
  endfunction

endpackage

// File: rtl/lec_prescaler.sv
module lec_prescaler #(
  parameter int HR_W = 6,
  parameter int LP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [HR_W-1:0] hr_div,
  input  logic [LP_W-1:0] lp_exp,
  output logic            hr_tick,
  output logic            loop_tick
);
  localparam int LPC_W = (1 << LP_W) - 1;

  logic [HR_W-1:0]  hr_cnt;
  logic [LPC_W-1:0] lp_cnt;
  logic [LPC_W-1:0] lp_max;

  assign lp_max    = LPC_W'((64'd1 << lp_exp) - 64'd1);
  assign hr_tick   = (hr_cnt == hr_div);
  assign loop_tick = hr_tick && (lp_cnt == lp_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr_cnt <= '0;
      lp_cnt <= '0;
    end else if (restart) begin
      hr_cnt <= '0;
      lp_cnt <= '0;
    end else if (hr_tick) begin
      hr_cnt <= '0;
      lp_cnt <= (lp_cnt == lp_max) ? '0 : lp_cnt + 1'b1;
    end else begin
      hr_cnt <= hr_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lec_sampler.sv
module lec_sampler
  import lec_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int PIN_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [PIN_W-1:0]    pin_sel,
  input  logic                loop_tick,
  input  edge_mode_e          mode,
  output logic                level_now,
  output logic                edge_hit
);
  logic [NUM_PINS-1:0] sync1, sync2;
  logic                held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pins;
      sync2 <= sync1;
    end
  end

  assign level_now = (int'(pin_sel) < NUM_PINS) ? sync2[pin_sel] : 1'b0;
  assign edge_hit  = loop_tick && edge_match(mode, held, level_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held <= 1'b0;
    else if (loop_tick) held <= level_now;
  end
endmodule

// File: rtl/lec_counter.sv
module lec_counter #(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_hit,
  input  logic             clr,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic accept;
  assign accept = edge_hit && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clr) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (accept && count != CNT_MAX) begin
      count <= count + 1'b1;
      if (count == CNT_MAX - 1'b1) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq <= 1'b0;
    else if (accept && irq_en) irq <= 1'b1;
    else if (irq_clr)          irq <= 1'b0;
  end
endmodule

// File: rtl/loop_edge_counter.sv
module loop_edge_counter
  import lec_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CNT_W    = 25,
  parameter int HR_W     = 6,
  parameter int LP_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq
);
  localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int LP_LSB = 8;
  localparam int PIN_LSB = 4;
  localparam int IEN_BIT = 8;

  logic [HR_W-1:0]  cfg_hr;
  logic [LP_W-1:0]  cfg_lp;
  edge_mode_e       ctl_mode;
  logic [PIN_W-1:0] ctl_pin;
  logic             ctl_irq_en;

  logic cfg_wr, ctl_wr, cnt_clr, irq_clr;
  logic hr_tick, loop_tick, level_now, edge_hit, ovf_q;
  logic [CNT_W-1:0] count_q;

  assign cfg_wr  = reg_wr && reg_addr == 2'd0;
  assign ctl_wr  = reg_wr && reg_addr == 2'd1;
  assign cnt_clr = reg_wr && reg_addr == 2'd2;
  assign irq_clr = reg_wr && reg_addr == 2'd3 && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_hr     <= '0;
      cfg_lp     <= '0;
      ctl_mode   <= EDGE_NONE;
      ctl_pin    <= '0;
      ctl_irq_en <= 1'b0;
    end else begin
      if (cfg_wr) begin
        cfg_hr <= reg_wdata[HR_W-1:0];
        cfg_lp <= reg_wdata[LP_LSB +: LP_W];
      end
      if (ctl_wr) begin
        ctl_mode   <= edge_mode_e'(reg_wdata[1:0]);
        ctl_pin    <= reg_wdata[PIN_LSB +: PIN_W];
        ctl_irq_en <= reg_wdata[IEN_BIT];
      end
    end
  end

  lec_prescaler #(.HR_W(HR_W), .LP_W(LP_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr),
    .hr_div(cfg_hr), .lp_exp(cfg_lp),
    .hr_tick(hr_tick), .loop_tick(loop_tick)
  );

  lec_sampler #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .pins(pins), .pin_sel(ctl_pin),
    .loop_tick(loop_tick), .mode(ctl_mode),
    .level_now(level_now), .edge_hit(edge_hit)
  );

  lec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .clr(cnt_clr),
    .irq_en(ctl_irq_en), .irq_clr(irq_clr),
    .count(count_q), .ovf(ovf_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[HR_W-1:0]        = cfg_hr;
        reg_rdata[LP_LSB +: LP_W]  = cfg_lp;
      end
      2'd1: begin
        reg_rdata[1:0]             = ctl_mode;
        reg_rdata[PIN_LSB +: PIN_W] = ctl_pin;
        reg_rdata[IEN_BIT]         = ctl_irq_en;
      end
      2'd2: reg_rdata[CNT_W-1:0]   = count_q;
      default: reg_rdata[1:0]      = {ovf_q, irq};
    endcase
  end
endmodule

// File: rtl/lec_checker.sv
module lec_checker #(
  parameter int CNT_W = 25,
  parameter int HR_W  = 6,
  parameter int LP_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hr_tick,
  input logic             loop_tick,
  input logic             cfg_wr,
  input logic [HR_W-1:0]  cfg_hr,
  input logic [LP_W-1:0]  cfg_lp,
  input logic             cnt_clr,
  input logic             irq_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  int unsigned hr_gap, lp_gap, period;
  assign period = lec_pkg::loop_period(int'(cfg_hr), int'(cfg_lp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hr_gap <= 1;
      lp_gap <= 1;
    end else begin
      hr_gap <= (cfg_wr || hr_tick)   ? 1 : hr_gap + 1;
      lp_gap <= (cfg_wr || loop_tick) ? 1 : lp_gap + 1;
    end
  end

  // R1
  hr_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hr_tick |-> hr_gap == int'(cfg_hr) + 1);
  // R2
  loop_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_tick |-> lp_gap == period);
  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (count == $past(count) || count == $past(count) + 1'b1));
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_tick && !cnt_clr) |=> $stable(count));
  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count == '0 && !ovf));
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !cnt_clr) |=> count == CNT_MAX);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cnt_clr) |=> ovf);
  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind loop_edge_counter lec_checker #(.CNT_W(CNT_W), .HR_W(HR_W), .LP_W(LP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hr_tick(hr_tick), .loop_tick(loop_tick),
  .cfg_wr(cfg_wr), .cfg_hr(cfg_hr), .cfg_lp(cfg_lp), .cnt_clr(cnt_clr),
  .irq_clr(irq_clr), .count(count_q), .ovf(ovf_q), .irq(irq)
);

// File: tb/test_loop_edge_counter.sv
module test_loop_edge_counter;
  localparam int NUM_PINS = 4;
  localparam int CNT_W    = 4;
  localparam int NV       = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_PINS-1:0] pins = '0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  loop_edge_counter #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) i_loop_edge_counter (
    .clk(clk), .rst_n(rst_n), .pins(pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {hr[5:0], lp[2:0], mode[1:0], hold[7:0], toggles[7:0], clear_at[7:0], expected[7:0]}
  localparam logic [42:0] VEC [NV] = '{
    {6'd0, 3'd0, 2'b01, 8'd4,  8'd6,  8'd255, 8'd3},  // R4 rising, R1 hr=0
    {6'd2, 3'd1, 2'b11, 8'd6,  8'd6,  8'd255, 8'd6},  // R1 R2 R4 both
    {6'd0, 3'd2, 2'b10, 8'd4,  8'd6,  8'd255, 8'd3},  // R4 falling
    {6'd1, 3'd2, 2'b01, 8'd4,  8'd10, 8'd4,   8'd0},  // R5 aliasing at loop rate
    {6'd0, 3'd0, 2'b00, 8'd3,  8'd6,  8'd255, 8'd0},  // R4 none
    {6'd0, 3'd5, 2'b01, 8'd32, 8'd4,  8'd255, 8'd2},  // R2 R3 0x500 setting
    {6'd3, 3'd2, 2'b11, 8'd40, 8'd5,  8'd255, 8'd5}   // R3 long holds
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic toggle_seq(input int p, input int hold, input int ntog, input int clr_at);
    for (int i = 0; i < ntog; i++) begin
      pins[p] = ~pins[p];
      if (i == clr_at) begin reg_addr = 2'd2; reg_wr = 1'b1; end
      @(negedge clk);
      reg_wr = 1'b0;
      repeat (hold - 1) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R-all actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R11 reset readback", int'(v), 0);
    end
    check(irq == 1'b0, "R11 reset irq", int'(irq), 0);

    // Vector table
    for (int n = 0; n < NV; n++) begin
      int hr, lp, md, hold, ntog, clr_at, exp_c, per;
      hr = int'(VEC[n][42:37]); lp = int'(VEC[n][36:34]); md = int'(VEC[n][33:32]);
      hold = int'(VEC[n][31:24]); ntog = int'(VEC[n][23:16]);
      clr_at = int'(VEC[n][15:8]); exp_c = int'(VEC[n][7:0]);
      per = (hr + 1) << lp;
      pins = '0;
      wr(2'd0, 32'(hr) | (32'(lp) << 8));
      wr(2'd1, 32'(md));
      repeat (3 * per + 4) @(negedge clk);
      wr(2'd2, 32'd0);
      toggle_seq(0, hold, ntog, clr_at);
      repeat (2 * per + 6) @(negedge clk);
      rd(2'd2, v);
      check(v == 32'(exp_c), $sformatf("R3/R4/R5 vector %0d count", n), int'(v), exp_c);
      if (n == 5) begin
        rd(2'd0, v);
        check(v == 32'h500, "R2 R11 config readback 0x500", int'(v), 32'h500);
      end
    end

    // Fast setup for directed tests
    pins = '0;
    wr(2'd0, 32'd0);

    // R10 pin select: pin 2 chosen, pin 0 toggled
    wr(2'd1, 32'h21);
    repeat (6) @(negedge clk);
    wr(2'd2, 32'd0);
    toggle_seq(0, 3, 4, 255);
    repeat (6) @(negedge clk);
    rd(2'd2, v);
    check(v == 0, "R10 other pin ignored", int'(v), 0);
    toggle_seq(2, 3, 4, 255);
    repeat (6) @(negedge clk);
    rd(2'd2, v);
    check(v == 2, "R10 selected pin counted", int'(v), 2);
    pins = '0;

    // R7 saturation with 4-bit counter
    wr(2'd1, 32'h01);
    repeat (6) @(negedge clk);
    wr(2'd2, 32'd0);
    toggle_seq(0, 2, 28, 255);
    repeat (6) @(negedge clk);
    rd(2'd2, v);
    check(v == 14, "R7 count below max", int'(v), 14);
    rd(2'd3, v);
    check(v[1] == 1'b0, "R7 ovf clear below max", int'(v[1]), 0);
    toggle_seq(0, 2, 2, 255);
    repeat (6) @(negedge clk);
    rd(2'd3, v);
    check(v[1] == 1'b1, "R7 ovf set at max", int'(v[1]), 1);
    toggle_seq(0, 2, 10, 255);
    repeat (6) @(negedge clk);
    rd(2'd2, v);
    check(v == 15, "R7 saturated count", int'(v), 15);
    wr(2'd2, 32'd0);
    rd(2'd2, v);
    check(v == 0, "R8 reset count", int'(v), 0);
    rd(2'd3, v);
    check(v[1] == 1'b0, "R8 reset clears ovf", int'(v[1]), 0);

    // R9 interrupt
    wr(2'd1, 32'h101);
    repeat (4) @(negedge clk);
    toggle_seq(0, 3, 2, 255);
    repeat (6) @(negedge clk);
    check(irq == 1'b1, "R9 irq on counted edge", int'(irq), 1);
    wr(2'd3, 32'd2);
    check(irq == 1'b1, "R9 write 0 to bit0 keeps irq", int'(irq), 1);
    wr(2'd3, 32'd1);
    check(irq == 1'b0, "R9 w1c clears irq", int'(irq), 0);

    // R8 reset strobe coincident with detected edge (loop tick every clock)
    wr(2'd2, 32'd0);
    repeat (4) @(negedge clk);
    pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(2'd2, 32'd0);
    repeat (4) @(negedge clk);
    rd(2'd2, v);
    check(v == 0, "R8 coincident edge dropped", int'(v), 0);
    check(irq == 1'b0, "R8 dropped edge no irq", int'(irq), 0);
    pins[0] = 1'b0;
    repeat (4) @(negedge clk);
    pins[0] = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd2, v);
    check(v == 1, "R8 later edge counted", int'(v), 1);

    summary();
  end
endmodule